// File: doc/BRIEF.md
# Demand-Type Handshake Receive Port

This block links one locally clocked island to an incoming four-phase request/acknowledge channel. The island uses it when it cannot continue without the next data word. The island raises its enable. The port then asks the clock generator to stop the island clock at once, and keeps that request up for the whole exchange. While the clock is stopped, the port waits for the sender's request, captures the word, acknowledges, and completes the return-to-zero half of the handshake. Only then does it drop the pause request.

The port is a synchronous state machine. It runs on a free-running reference clock that is independent of the island clock. The channel request crosses a small synchronizer. The clock generator answers the pause request with a grant. The island clock may tick only while both pause request and grant are low. The first island edge after a transfer therefore sees the new word already stable on the data register. If the island keeps its enable high across that edge, the next transfer starts straight away.

Top module: `dport_ctrl`

## Requirements
- R1: While rst_ni is low, ch_ack_o and pause_req_o are 0 and data_o is all zeros.
- R2: In the idle state, pause_req_o follows en_i combinationally, so the pause request is raised in the same reference cycle as the enable.
- R3: Once raised for a transfer, pause_req_o stays 1 until ch_ack_o falls, so the island gets no clock edge between enable and the completion of the data capture.
- R4: ch_ack_o is never raised while pause_gnt_i is 0; a channel request that arrives before the grant is held off.
- R5: With the grant already present, ch_ack_o rises on the third reference edge after ch_req_i rises (SYNC_STAGES = 2 plus one state edge), and data_o takes the value ch_data_i had just before that edge.
- R6: ch_ack_o stays 1 as long as the synchronized request is 1. It falls on the third reference edge after ch_req_i falls, and pause_req_o falls at the same edge.
- R7: After the handshake ends, no new pause request is issued until pause_gnt_i has returned to 0, even with en_i held high.
- R8: If en_i is still 1 at the first island edge after a transfer, pause_req_o is high again in the next reference cycle, and successive words arrive in order.
- R9: data_o changes only at the edge where ch_ack_o rises. Channel activity while idle, or data changes after the acknowledge falls, leave data_o, ch_ack_o and pause_req_o unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Island enable: demand the next word |
| data_o | output | DATA_W | Captured word presented to the island |
| ch_req_i | input | 1 | Channel request from the sender (asynchronous) |
| ch_ack_o | output | 1 | Channel acknowledge to the sender |
| ch_data_i | input | DATA_W | Channel data, valid while ch_req_i is high |
| pause_req_o | output | 1 | Request to stop the island clock |
| pause_gnt_i | input | 1 | Clock generator grant: island clock stopped |

## Verification
The assertions assume that the sender obeys the four-phase order. It holds ch_data_i steady from before raising ch_req_i until ch_ack_o is high, and it drops ch_req_i only after seeing the acknowledge. They also assume that pause_gnt_i is synchronous to the reference clock, rises only after pause_req_o, and falls only after pause_req_o has fallen. Finally, they assume that the island changes en_i only at its own clock edges. The bench keeps to all three. It uses a modelled clock generator whose grant follows the pause request after a programmable delay. Its sender waits for the acknowledge before releasing the request, and it updates the enable only just after an edge where the island clock is allowed.

// File: rtl/dport_pkg.sv
package dport_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PAUSE,
    ST_WAIT_REQ,
    ST_LATCH,
    ST_WAIT_REQ_LOW,
    ST_RELEASE
  } dport_state_e;
endpackage

// File: rtl/dport_sync.sv
module dport_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/dport_fsm.sv
module dport_fsm
  import dport_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic req_s_i,
  input  logic gnt_i,
  output logic capture_o,
  output logic ack_o,
  output logic pause_req_o
);
  dport_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:         if (en_i)     state_d = ST_PAUSE;
      ST_PAUSE:        if (gnt_i)    state_d = ST_WAIT_REQ;
      ST_WAIT_REQ:     if (req_s_i)  state_d = ST_LATCH;
      ST_LATCH:                      state_d = ST_WAIT_REQ_LOW;
      ST_WAIT_REQ_LOW: if (!req_s_i) state_d = ST_RELEASE;
      ST_RELEASE:      if (!gnt_i)   state_d = ST_IDLE;
      default:                       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign capture_o = (state_q == ST_WAIT_REQ) && req_s_i;
  assign ack_o     = (state_q == ST_LATCH) || (state_q == ST_WAIT_REQ_LOW);
  // combinational in idle so the island clock stops in the enable cycle
  assign pause_req_o = ((state_q == ST_IDLE) && en_i) ||
                       (state_q == ST_PAUSE) || (state_q == ST_WAIT_REQ) ||
                       ack_o;
endmodule

// File: rtl/dport_dreg.sv
module dport_dreg #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/dport_ctrl.sv
module dport_ctrl #(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  output logic [DATA_W-1:0] data_o,
  input  logic              ch_req_i,
  output logic              ch_ack_o,
  input  logic [DATA_W-1:0] ch_data_i,
  output logic              pause_req_o,
  input  logic              pause_gnt_i
);
  logic req_s;
  logic capture;

  dport_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ch_req_i),
    .q_o    (req_s)
  );

  dport_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .req_s_i     (req_s),
    .gnt_i       (pause_gnt_i),
    .capture_o   (capture),
    .ack_o       (ch_ack_o),
    .pause_req_o (pause_req_o)
  );

  dport_dreg #(.WIDTH(DATA_W)) u_dreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (capture),
    .d_i    (ch_data_i),
    .q_o    (data_o)
  );
endmodule

// File: rtl/dport_ctrl_chk.sv
module dport_ctrl_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] data_o,
  input logic              ch_req_i,
  input logic              ch_ack_o,
  input logic [DATA_W-1:0] ch_data_i,
  input logic              pause_req_o,
  input logic              pause_gnt_i
);
  // R1
  always_comb begin
    if (!rst_ni) begin
      rst_quiet_chk: assert (!ch_ack_o && !pause_req_o);
    end
  end

  // R4
  ack_needs_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_ack_o |-> pause_gnt_i);

  // R3
  ack_under_pause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_ack_o |-> pause_req_o);

  // R3
  pause_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pause_req_o) |-> $fell(ch_ack_o));

  // R6
  ack_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ch_ack_o) |-> !ch_req_i);

  // R5
  ack_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ch_ack_o) |-> (data_o == $past(ch_data_i)));

  // R9
  data_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_o) |-> $rose(ch_ack_o));
endmodule

bind dport_ctrl dport_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .data_o      (data_o),
  .ch_req_i    (ch_req_i),
  .ch_ack_o    (ch_ack_o),
  .ch_data_i   (ch_data_i),
  .pause_req_o (pause_req_o),
  .pause_gnt_i (pause_gnt_i)
);

// File: tb/dport_ctrl_test.sv
module dport_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic          clk = 0;
  logic          rst_ni = 0;
  logic          en_i = 0;
  logic [DW-1:0] data_o;
  logic          ch_req = 0;
  logic          ch_ack_o;
  logic [DW-1:0] ch_data = '0;
  logic          pause_req_o;
  logic          gnt = 0;

  int checks = 0;
  int errors = 0;
  int gnt_dly = 1;
  int gcnt = 0;
  int isl_edges = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dport_ctrl #(.DATA_W(DW), .SYNC_STAGES(2)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .data_o      (data_o),
    .ch_req_i    (ch_req),
    .ch_ack_o    (ch_ack_o),
    .ch_data_i   (ch_data),
    .pause_req_o (pause_req_o),
    .pause_gnt_i (gnt)
  );

  // clock generator model: grant follows pause request after gnt_dly edges
  always @(posedge clk) begin
    if (pause_req_o != gnt) begin
      if (gcnt >= gnt_dly) begin
        gnt  <= pause_req_o;
        gcnt = 0;
      end else gcnt++;
    end else gcnt = 0;
  end

  // island clock ticks only while neither pause request nor grant is up
  always @(posedge clk) if (rst_ni && !pause_req_o && !gnt) isl_edges++;

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_xfer(input logic [DW-1:0] w, input int pre, input int hold,
                         input bit keep, input bit lat);
    int e0;
    int n;
    @(negedge clk);
    if (en_i) check(pause_req_o == 1'b1, "R8 re-request", pause_req_o, 1);
    en_i = 1;
    e0 = isl_edges;
    #1 check(pause_req_o == 1'b1, "R2 immediate pause", pause_req_o, 1);
    if (lat) begin
      while (!gnt) @(negedge clk);
      repeat (2) @(negedge clk);
    end else repeat (pre) @(negedge clk);
    ch_data = w;
    ch_req  = 1;
    n = 0;
    while (!ch_ack_o) begin
      @(negedge clk);
      n++;
      if (!gnt) check(!ch_ack_o, "R4 ack before grant", ch_ack_o, 0);
    end
    if (lat) check(n == 3, "R5 ack latency", n, 3);
    check(data_o == w, "R5 captured word", data_o, w);
    check(isl_edges == e0, "R3 no island edge", isl_edges, e0);
    repeat (hold) begin
      @(negedge clk);
      check(ch_ack_o == 1'b1, "R6 ack held", ch_ack_o, 1);
    end
    ch_req = 0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (ch_ack_o);
    check(n == 3, "R6 ack fall latency", n, 3);
    check(pause_req_o == 1'b0, "R6 pause drops with ack", pause_req_o, 0);
    ch_data = ~w;
    check(isl_edges == e0, "R3 no island edge", isl_edges, e0);
    while (pause_req_o || gnt) begin
      check(pause_req_o == 1'b0, "R7 wait grant low", pause_req_o, 0);
      @(negedge clk);
    end
    check(data_o == w, "R9 word at island edge", data_o, w);
    @(posedge clk);
    #1 en_i = keep;
  endtask

  task automatic t_reset;
    check(ch_ack_o == 1'b0, "R1 ack", ch_ack_o, 0);
    check(pause_req_o == 1'b0, "R1 pause", pause_req_o, 0);
    check(data_o == '0, "R1 data", data_o, 0);
  endtask

  task automatic t_single;
    gnt_dly = 1;
    do_xfer(32'hA5C3_0F01, 0, 2, 1'b0, 1'b1);
  endtask

  task automatic t_early_req;
    gnt_dly = 6;
    do_xfer(32'h1234_5678, 0, 1, 1'b0, 1'b0);
  endtask

  task automatic t_slow_release;
    gnt_dly = 8;
    do_xfer(32'h0BAD_F00D, 1, 0, 1'b0, 1'b0);
  endtask

  task automatic t_stream;
    logic [DW-1:0] w;
    for (int i = 0; i < 8; i++) begin
      gnt_dly = $urandom_range(0, 3);
      w = 32'hC000_0000 + i * 32'h0101_0101;
      do_xfer(w, $urandom_range(0, 5), $urandom_range(0, 4), i != 7, 1'b0);
      check(data_o == w, "R8 in-order word", data_o, w);
    end
  endtask

  task automatic t_idle_noise;
    logic [DW-1:0] d0;
    @(negedge clk);
    d0 = data_o;
    ch_data = 32'hFFFF_0000;
    ch_req  = 1;
    repeat (6) @(negedge clk);
    check(ch_ack_o == 1'b0, "R9 idle ack", ch_ack_o, 0);
    check(pause_req_o == 1'b0, "R9 idle pause", pause_req_o, 0);
    check(data_o == d0, "R9 idle data", data_o, d0);
    ch_req = 0;
    repeat (5) @(negedge clk);
    check(data_o == d0, "R9 idle data after", data_o, d0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    repeat (2) @(negedge clk);
    t_single();
    t_early_req();
    t_slow_release();
    t_idle_noise();
    t_stream();
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule